// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block sits at the head of a receive path and decides, from the 48-bit destination address of an incoming frame, whether the frame is for this station. The address is presented one byte per cycle, first byte first, with a marker on the first byte. A fixed number of cycles after the sixth byte, the block gives a one-cycle result strobe together with an accept flag.

The filter holds a station address, a 64-bit multicast hash table and three mode bits, all as 16-bit configuration words written through a simple word-write port. Each frame is judged by a fixed priority. Promiscuous mode accepts everything. The all-ones broadcast address comes next. A match with the station address is accepted next. Any other group address is looked up in the hash table, but only when the table is not empty. The hash index comes from a CRC-32 that is built up byte by byte while the address streams in, so no extra cycles are spent on it.

Top module: `dst_addr_filter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the hash table is cleared, the mode bits are cleared and the station address is loaded from `prom_addr`, with station byte n taken from bits [8n+7:8n]. `res_vld` is low after reset.
- R2: A byte with `da_vld` and `da_first` both high is address byte 0. Each later `da_vld` byte fills bytes 1 to 5 in turn. A new `da_first` restarts the address at byte 0. Bytes after the sixth, and `da_vld` bytes when no address is open, are ignored and produce no result.
- R3: When byte 5 is sampled at rising edge E, `res_vld` is high for exactly the one cycle that follows edge E+1. `res_accept` is valid in that cycle.
- R4: When `cfg_wr` is high at an edge, `cfg_data` is written to the word selected by `cfg_idx`. Index k in 0..3 is hash word k, which holds table bits [16k+15:16k]. Index 4+j in 0..2 is station word j, whose low byte is station byte 2j and whose high byte is byte 2j+1. Index 7 is the mode word.
- R5: A destination equal to the station address is accepted unless mode bit 13 (physical match disable) is 1.
- R6: The all-ones broadcast address is accepted when mode bit 14 (broadcast disable) is 0 and rejected when it is 1. This decision is taken before the hash lookup.
- R7: A group address (bit 0 of byte 0 set) that is not broadcast and does not hit the station rule is looked up in the hash table when the table is nonzero. The index is bits [31:26] of a CRC-32 register preset to all ones, using the reflected polynomial 0xEDB88320 and fed the six bytes in order, each byte LSB first, with no final inversion. The frame is accepted exactly when table bit [index] is 1.
- R8: When the whole hash table is zero, a group address that is not broadcast is rejected unless another rule accepts it. An individual address (byte 0 bit 0 clear) never uses the hash table.
- R9: When mode bit 15 (promiscuous) is 1, every address is accepted, including broadcast while broadcast is disabled.
- R10: Any address that no rule accepts is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prom_addr | input | 48 | Station address loaded at reset; byte n in bits [8n+7:8n] |
| cfg_wr | input | 1 | Configuration word write strobe |
| cfg_idx | input | 3 | Configuration word select |
| cfg_data | input | 16 | Configuration word data |
| da_vld | input | 1 | Destination address byte valid |
| da_first | input | 1 | Marks byte 0 of a destination address |
| da_byte | input | 8 | Destination address byte |
| res_vld | output | 1 | One-cycle result strobe |
| res_accept | output | 1 | Accept decision, valid with res_vld |

## Verification
The station address is tried in its reset value and again after a rewrite. A variant with two bytes swapped tells a correct byte order in the words from a wrong one. Broadcast is sent with a full hash table and broadcast disabled, which shows that the broadcast rule takes priority over a hash lookup that would accept it. One group address is sent against a table holding only its own index bit and then against the complement of that table. This pins down the CRC index and the bit order in the table. An individual address against a full table shows the group-bit gate, and a group address against an empty table shows the empty-table rule. Framing patterns cover a restart in mid-address, trailing bytes and stray bytes with no open address, and tell apart a byte counter that restarts, runs over or wakes up on its own.

// File: rtl/dst_filt_pkg.sv
// Shared constants, the mode-bit record and the byte-wide CRC step
// for the destination address filter.
package dst_filt_pkg;
    localparam int BYTE_W     = 8;
    localparam int ADDR_BYTES = 6;
    localparam int ADDR_W     = BYTE_W * ADDR_BYTES;
    localparam int WORD_W     = 16;
    localparam int HASH_BITS  = 6;
    localparam int TBL_W      = 1 << HASH_BITS;
    localparam int TBL_WORDS  = TBL_W / WORD_W;
    localparam int STA_WORDS  = ADDR_W / WORD_W;
    localparam int STA_BASE   = TBL_WORDS;
    localparam int MODE_IDX   = TBL_WORDS + STA_WORDS;
    localparam int CFG_IDX_W  = $clog2(MODE_IDX + 1);
    localparam int CRC_W      = 32;
    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;

    // Mode bit positions inside the mode word
    localparam int MODE_NOPHYS_BIT = 13;
    localparam int MODE_NOBC_BIT   = 14;
    localparam int MODE_PROM_BIT   = 15;

    typedef struct packed {
        logic promisc;
        logic no_bcast;
        logic no_phys;
    } mode_t;

    // Fold one byte into a reflected CRC register, LSB first
    function automatic logic [CRC_W-1:0] crc_fold_byte(
        input logic [CRC_W-1:0]  crc_in,
        input logic [BYTE_W-1:0] data
    );
        logic [CRC_W-1:0] c;
        c = crc_in;
        for (int b = 0; b < BYTE_W; b++) begin
            if (c[0] ^ data[b]) c = (c >> 1) ^ CRC_POLY_REFL;
            else                c = c >> 1;
        end
        return c;
    endfunction
endpackage

// File: rtl/dst_filt_cfg.sv
// Configuration storage: hash table words, station address words and
// mode bits. Assumes at most one word write per cycle; the station
// address is reloaded from prom_addr on every reset cycle.
module dst_filt_cfg
    import dst_filt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [CFG_IDX_W-1:0] cfg_idx,
    input  logic [WORD_W-1:0]    cfg_data,
    input  logic [ADDR_W-1:0]    prom_addr,
    output logic [ADDR_W-1:0]    station,
    output logic [TBL_W-1:0]     hash_tbl,
    output mode_t                mode
);
    logic [WORD_W-1:0] tbl_w [TBL_WORDS];
    logic [WORD_W-1:0] sta_w [STA_WORDS];

    // Hash table words: cleared at reset, written by index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < TBL_WORDS; k++) tbl_w[k] <= '0;
        end else if (cfg_wr) begin
            for (int k = 0; k < TBL_WORDS; k++)
                if (cfg_idx == CFG_IDX_W'(k)) tbl_w[k] <= cfg_data;
        end
    end

    // Station words: loaded from the address input at reset, written by index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < STA_WORDS; j++)
                sta_w[j] <= prom_addr[j*WORD_W +: WORD_W];
        end else if (cfg_wr) begin
            for (int j = 0; j < STA_WORDS; j++)
                if (cfg_idx == CFG_IDX_W'(STA_BASE + j)) sta_w[j] <= cfg_data;
        end
    end

    // Mode bits: cleared at reset, taken from the mode word on write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= '0;
        end else if (cfg_wr && cfg_idx == CFG_IDX_W'(MODE_IDX)) begin
            mode.promisc  <= cfg_data[MODE_PROM_BIT];
            mode.no_bcast <= cfg_data[MODE_NOBC_BIT];
            mode.no_phys  <= cfg_data[MODE_NOPHYS_BIT];
        end
    end

    genvar g;
    generate
        for (g = 0; g < TBL_WORDS; g++) begin : g_tbl_flat
            assign hash_tbl[g*WORD_W +: WORD_W] = tbl_w[g];
        end
        for (g = 0; g < STA_WORDS; g++) begin : g_sta_flat
            assign station[g*WORD_W +: WORD_W] = sta_w[g];
        end
    endgenerate
endmodule

// File: rtl/dst_filt_collect.sv
// Gathers the destination address bytes. A first-marked byte opens a
// new address at byte 0; unmarked bytes fill the remaining slots while
// an address is open. Pulses addr_done on the edge after the last byte.
module dst_filt_collect
    import dst_filt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              da_vld,
    input  logic              da_first,
    input  logic [BYTE_W-1:0] da_byte,
    output logic              take,
    output logic [ADDR_W-1:0] dest,
    output logic              addr_done
);
    localparam int CNT_W = $clog2(ADDR_BYTES + 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  slot;
    logic              open_slot;
    logic [BYTE_W-1:0] lane_q [ADDR_BYTES];

    assign open_slot = (cnt_q != '0) && (cnt_q < CNT_W'(ADDR_BYTES));
    assign take      = da_vld && (da_first || open_slot);
    assign slot      = da_first ? '0 : cnt_q;

    // Byte counter: next free slot, parked at ADDR_BYTES once full
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (take) cnt_q <= slot + 1'b1;
    end

    // Byte lanes: store each taken byte in its slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ADDR_BYTES; i++) lane_q[i] <= '0;
        end else begin
            for (int i = 0; i < ADDR_BYTES; i++)
                if (take && slot == CNT_W'(i)) lane_q[i] <= da_byte;
        end
    end

    // Completion pulse: the last slot was filled this edge
    always_ff @(posedge clk) begin
        if (!rst_n) addr_done <= 1'b0;
        else        addr_done <= take && (slot == CNT_W'(ADDR_BYTES - 1));
    end

    genvar g;
    generate
        for (g = 0; g < ADDR_BYTES; g++) begin : g_lane_flat
            assign dest[g*BYTE_W +: BYTE_W] = lane_q[g];
        end
    endgenerate
endmodule

// File: rtl/dst_filt_crc.sv
// Running CRC-32 over the address bytes, reflected form, preset to all
// ones on the first byte. The hash index is the top HASH_BITS bits of
// the register, with no final inversion.
module dst_filt_crc
    import dst_filt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step,
    input  logic                 restart,
    input  logic [BYTE_W-1:0]    data,
    output logic [HASH_BITS-1:0] hash_idx
);
    logic [CRC_W-1:0] crc_q;

    // CRC register: restart from all ones or continue the running value
    always_ff @(posedge clk) begin
        if (!rst_n)    crc_q <= '1;
        else if (step) crc_q <= crc_fold_byte(restart ? '1 : crc_q, data);
    end

    assign hash_idx = crc_q[CRC_W-1 -: HASH_BITS];
endmodule

// File: rtl/dst_filt_decide.sv
// Applies the acceptance rules to a complete address in priority order
// (promiscuous, broadcast, station match, hash) and registers the
// result strobe and flag.
module dst_filt_decide
    import dst_filt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 addr_done,
    input  logic [ADDR_W-1:0]    dest,
    input  logic [HASH_BITS-1:0] hash_idx,
    input  logic [ADDR_W-1:0]    station,
    input  logic [TBL_W-1:0]     hash_tbl,
    input  mode_t                mode,
    output logic                 res_vld,
    output logic                 res_accept
);
    logic is_bcast, phys_hit, group, tbl_any, verdict;

    // Rule evaluation in fixed priority
    always_comb begin
        is_bcast = &dest;
        phys_hit = (dest == station);
        group    = dest[0];
        tbl_any  = |hash_tbl;
        if (mode.promisc)                 verdict = 1'b1;
        else if (is_bcast)                verdict = !mode.no_bcast;
        else if (phys_hit && !mode.no_phys) verdict = 1'b1;
        else if (group && tbl_any)        verdict = hash_tbl[hash_idx];
        else                              verdict = 1'b0;
    end

    // Result register: one strobe per completed address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld    <= 1'b0;
            res_accept <= 1'b0;
        end else begin
            res_vld    <= addr_done;
            res_accept <= addr_done && verdict;
        end
    end
endmodule

// File: rtl/dst_addr_filter.sv
// Top of the destination address filter: configuration storage, byte
// collection, running hash and the decision stage. Assumes one address
// byte per cycle at most.
module dst_addr_filter
    import dst_filt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    prom_addr,
    input  logic                 cfg_wr,
    input  logic [CFG_IDX_W-1:0] cfg_idx,
    input  logic [WORD_W-1:0]    cfg_data,
    input  logic                 da_vld,
    input  logic                 da_first,
    input  logic [BYTE_W-1:0]    da_byte,
    output logic                 res_vld,
    output logic                 res_accept
);
    logic [ADDR_W-1:0]    station_addr;
    logic [TBL_W-1:0]     hash_tbl;
    mode_t                mode_q;
    logic                 byte_take;
    logic [ADDR_W-1:0]    dest_addr;
    logic                 addr_done;
    logic [HASH_BITS-1:0] hash_idx;

    dst_filt_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_idx   (cfg_idx),
        .cfg_data  (cfg_data),
        .prom_addr (prom_addr),
        .station   (station_addr),
        .hash_tbl  (hash_tbl),
        .mode      (mode_q)
    );

    dst_filt_collect u_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .da_vld    (da_vld),
        .da_first  (da_first),
        .da_byte   (da_byte),
        .take      (byte_take),
        .dest      (dest_addr),
        .addr_done (addr_done)
    );

    dst_filt_crc u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (byte_take),
        .restart  (da_first),
        .data     (da_byte),
        .hash_idx (hash_idx)
    );

    dst_filt_decide u_decide (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_done  (addr_done),
        .dest       (dest_addr),
        .hash_idx   (hash_idx),
        .station    (station_addr),
        .hash_tbl   (hash_tbl),
        .mode       (mode_q),
        .res_vld    (res_vld),
        .res_accept (res_accept)
    );
endmodule

// File: rtl/dst_addr_filter_chk.sv
// Property checker for the destination address filter, bound to the top.
// Observes the result port against the collected address and the stored
// configuration one cycle earlier.
module dst_addr_filter_chk
    import dst_filt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              res_vld,
    input logic              res_accept,
    input logic              addr_done,
    input logic [ADDR_W-1:0] dest_addr,
    input logic [ADDR_W-1:0] station_addr,
    input logic [TBL_W-1:0]  hash_tbl,
    input logic              m_prom,
    input logic              m_nobc,
    input logic              m_nophys
);
    // R3
    res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |=> !res_vld);

    // R3
    res_after_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> $past(addr_done));

    // R9
    promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && $past(m_prom)) |-> res_accept);

    // R6
    bcast_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && $past((&dest_addr) && m_nobc && !m_prom)) |-> !res_accept);

    // R8
    empty_tbl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && $past(dest_addr[0] && !(&dest_addr) && (hash_tbl == '0)
            && !m_prom && ((dest_addr != station_addr) || m_nophys))) |-> !res_accept);
endmodule

bind dst_addr_filter dst_addr_filter_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .res_vld      (res_vld),
    .res_accept   (res_accept),
    .addr_done    (addr_done),
    .dest_addr    (dest_addr),
    .station_addr (station_addr),
    .hash_tbl     (hash_tbl),
    .m_prom       (mode_q.promisc),
    .m_nobc       (mode_q.no_bcast),
    .m_nophys     (mode_q.no_phys)
);

// File: tb/dst_addr_filter_tb_top.sv
// Directed bench for the destination address filter.
module dst_addr_filter_tb_top;
    localparam time CLK_P = 10ns;
    localparam logic [47:0] PROM = 48'hA5B4C3D2E1F0;
    localparam logic [47:0] BCAST = '1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] prom_addr = PROM;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [15:0] cfg_data = '0;
    logic        da_vld = 1'b0;
    logic        da_first = 1'b0;
    logic [7:0]  da_byte = '0;
    logic        res_vld;
    logic        res_accept;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    dst_addr_filter dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .prom_addr  (prom_addr),
        .cfg_wr     (cfg_wr),
        .cfg_idx    (cfg_idx),
        .cfg_data   (cfg_data),
        .da_vld     (da_vld),
        .da_first   (da_first),
        .da_byte    (da_byte),
        .res_vld    (res_vld),
        .res_accept (res_accept)
    );

    // Record one check; print a failure line when it does not hold
    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected hash index from the rule in R7
    function automatic logic [5:0] ref_idx(input logic [47:0] a);
        logic [31:0] c = '1;
        for (int i = 0; i < 48; i++) begin
            if (c[0] ^ a[i]) c = (c >> 1) ^ 32'hEDB88320;
            else             c = c >> 1;
        end
        return c[31:26];
    endfunction

    task automatic cfg_write(input logic [2:0] idx, input logic [15:0] d);
        @(negedge clk); cfg_wr = 1'b1; cfg_idx = idx; cfg_data = d;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic set_table(input logic [63:0] t);
        for (int k = 0; k < 4; k++) cfg_write(3'(k), t[16*k +: 16]);
    endtask

    task automatic set_mode(input bit prom, input bit nobc, input bit nophys);
        cfg_write(3'd7, {prom, nobc, nophys, 13'd0});
    endtask

    task automatic drive_byte(input logic [7:0] b, input bit first);
        @(negedge clk); da_vld = 1'b1; da_first = first; da_byte = b;
    endtask

    // Send a full address and check strobe timing and decision (R3)
    task automatic send_frame(input logic [47:0] a, input bit exp, input string tag);
        for (int i = 0; i < 6; i++) drive_byte(a[8*i +: 8], i == 0);
        @(negedge clk); da_vld = 1'b0; da_first = 1'b0;
        check(res_vld == 1'b0, "R3 early strobe", 64'(res_vld), 0);
        @(negedge clk);
        check(res_vld == 1'b1, "R3 strobe", 64'(res_vld), 1);
        check(res_accept == exp, tag, 64'(res_accept), 64'(exp));
        @(negedge clk);
        check(res_vld == 1'b0, "R3 pulse width", 64'(res_vld), 0);
    endtask

    // Watch for no result over n cycles (R2)
    task automatic expect_quiet(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(res_vld == 1'b0, tag, 64'(res_vld), 0);
        end
    endtask

    task automatic t_reset;
        check(res_vld == 1'b0, "R1 reset strobe", 64'(res_vld), 0);
        send_frame(PROM, 1'b1, "R1 R5 station from prom");
        send_frame(48'h00000000A001, 1'b0, "R1 R8 empty table group");
        send_frame(48'h112233445566, 1'b0, "R10 other unicast");
    endtask

    task automatic t_station;
        cfg_write(3'd4, 16'h2210);
        cfg_write(3'd5, 16'h4433);
        cfg_write(3'd6, 16'h6655);
        send_frame(48'h665544332210, 1'b1, "R4 new station");
        send_frame(48'h556644332210, 1'b0, "R4 byte order");
        send_frame(PROM, 1'b0, "R4 old station gone");
        set_mode(1'b0, 1'b0, 1'b1);
        send_frame(48'h665544332210, 1'b0, "R5 phys disabled");
        set_mode(1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_bcast;
        send_frame(BCAST, 1'b1, "R6 bcast accept");
        set_table('1);
        set_mode(1'b0, 1'b1, 1'b0);
        send_frame(BCAST, 1'b0, "R6 bcast disabled over hash");
        set_mode(1'b0, 1'b0, 1'b0);
        set_table('0);
    endtask

    task automatic t_hash;
        logic [47:0] m;
        logic [5:0]  ix;
        m  = 48'h200000005E01;
        ix = ref_idx(m);
        set_table(64'd1 << ix);
        send_frame(m, 1'b1, "R7 hash bit set");
        set_table(~(64'd1 << ix));
        send_frame(m, 1'b0, "R7 hash bit clear");
        set_table('1);
        send_frame(48'h0A0B0C0D0E02, 1'b0, "R8 unicast skips hash");
        set_table('0);
        send_frame(m, 1'b0, "R8 empty table");
    endtask

    task automatic t_promisc;
        set_mode(1'b1, 1'b1, 1'b1);
        send_frame(48'h0A0B0C0D0E02, 1'b1, "R9 promisc unicast");
        send_frame(BCAST, 1'b1, "R9 promisc bcast");
        set_mode(1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_framing;
        // stray bytes with no open address
        for (int i = 0; i < 6; i++) drive_byte(8'h66, 1'b0);
        @(negedge clk); da_vld = 1'b0;
        expect_quiet(3, "R2 stray bytes");
        // partial junk then restart with a fresh first byte
        for (int i = 0; i < 3; i++) drive_byte(8'hFF, i == 0);
        send_frame(48'h665544332210, 1'b1, "R2 restart");
        // trailing bytes after a complete address
        for (int i = 0; i < 4; i++) drive_byte(8'h10, 1'b0);
        @(negedge clk); da_vld = 1'b0;
        expect_quiet(3, "R2 trailing bytes");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_station();
        t_bcast();
        t_hash();
        t_promisc();
        t_framing();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule